// File: doc/BRIEF.md
# Host Controller Run/Halt/Reset Sequencer

This block is the command and status core of a USB 2.0 host controller. It holds the run command bit, the self-clearing controller reset bit and the halted status bit. It steps the controller through four states: halted, running, halting and resetting. Software drives it through a single-cycle register write strobe. A transaction engine reports whether a USB transaction is in flight or has just finished. A memory-read status input reports failed fetches.

The outputs are the three visible bits and a schedule-enable level. A reset also produces one-cycle strobes for aborting the current transaction, for resetting operational and port logic, and for handing port ownership back to the companion controller. The block has no streaming data path; every pin is a plain control or status level or strobe. No valid/ready handshake is involved.

Top module: `hc_run_ctrl`

## Requirements
- R1: After `rst_n` is released, run_bit=0, halted=1, reset_bit=0 and sched_en=0.
- R2: A write carries the run bit in wr_data[0] and the reset bit in wr_data[1]. A write with wr_data=2'b01 while halted makes run_bit=1 and halted=0 together in the next cycle.
- R3: run_bit and halted are never 1 at the same time.
- R4: A write with wr_data[0]=0 (and wr_data[1]=0) while running enters halting (run_bit=0, halted=0). Halted is set in the cycle after the first cycle in which txn_active is low or txn_done is high.
- R5: While running, a cycle with mem_rd_valid=1 and mem_rd_ok=0 clears run_bit in the next cycle and enters halting. A read with mem_rd_ok=1 leaves run_bit at 1.
- R6: A write with wr_data[1]=1 in any state other than resetting sets reset_bit for exactly RST_CYCLES (default 16) cycles. The block then returns to run_bit=0, halted=1, reset_bit=0. In the same write, the reset bit takes precedence over the run bit.
- R7: While reset_bit is 1, every write is ignored. A write of 0 does not end the reset, and a write of 1 to the run bit does not set run_bit.
- R8: In the first cycle of a reset, txn_abort, op_rst and own_revert are each 1 for exactly one cycle.
- R9: sched_en is 1 exactly while the controller is running.
- R10: A write with wr_data=2'b01 while halting returns the controller to running in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous chip reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 2 | Write data: bit 0 run, bit 1 controller reset |
| txn_active | input | 1 | A USB transaction is in flight |
| txn_done | input | 1 | The current transaction has just completed |
| mem_rd_valid | input | 1 | A memory read status is presented |
| mem_rd_ok | input | 1 | That read completed successfully |
| run_bit | output | 1 | Run command bit as read by software |
| halted | output | 1 | Halted status bit |
| reset_bit | output | 1 | Controller reset bit, 1 while reset is in progress |
| sched_en | output | 1 | Schedule execution enable |
| txn_abort | output | 1 | Strobe: abort the transaction in flight |
| op_rst | output | 1 | Strobe: reset operational and port logic |
| own_revert | output | 1 | Strobe: return port ownership to the companion controller |

## Verification
Writes, transaction-engine inputs and read-status inputs all take effect on the next clock edge. The status bits and sched_en are therefore valid in the cycle after the stimulus. The reset strobes appear in that same first cycle and are gone one cycle later. The reset bit stays set for RST_CYCLES cycles counted from that first cycle, and the halted state follows in the next one. The bench drives inputs and samples outputs on the falling edge. It advances a known number of rising edges before each check, so every sample lands inside the cycle in which the result is due.

// File: rtl/hcrc_pkg.sv
package hcrc_pkg;
  typedef enum logic [1:0] {
    ST_HALTED  = 2'd0,
    ST_RUNNING = 2'd1,
    ST_HALTING = 2'd2,
    ST_RESET   = 2'd3
  } hc_state_e;

  localparam int WR_W    = 2;
  localparam int RUN_POS = 0;
  localparam int RST_POS = 1;
endpackage

// File: rtl/hcrc_wr_dec.sv
module hcrc_wr_dec
  import hcrc_pkg::*;
(
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  output logic            req_reset,
  output logic            req_run_set,
  output logic            req_run_clr
);
  // Reset wins over the run bit in the same write.
  always_comb begin
    req_reset   = wr_en & wr_data[RST_POS];
    req_run_set = wr_en & wr_data[RUN_POS] & ~wr_data[RST_POS];
    req_run_clr = wr_en & ~wr_data[RUN_POS] & ~wr_data[RST_POS];
  end
endmodule

// File: rtl/hcrc_rst_timer.sv
module hcrc_rst_timer #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic first,
  output logic done
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (start)                 cnt_q <= '0;
    else if (active && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign first = active && (cnt_q == '0);
  assign done  = active && (cnt_q == LAST);
endmodule

// File: rtl/hcrc_seq.sv
module hcrc_seq
  import hcrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_reset,
  input  logic      req_run_set,
  input  logic      req_run_clr,
  input  logic      txn_active,
  input  logic      txn_done,
  input  logic      mem_fail,
  input  logic      rst_first,
  input  logic      rst_done,
  output hc_state_e state,
  output hc_state_e nxt,
  output logic      rst_start,
  output logic      rst_active,
  output logic      sched_en,
  output logic      reset_strobe
);
  hc_state_e state_q;

  always_comb begin
    nxt       = state_q;
    rst_start = 1'b0;
    if (state_q == ST_RESET) begin
      if (rst_done) nxt = ST_HALTED;
    end else if (req_reset) begin
      nxt       = ST_RESET;
      rst_start = 1'b1;
    end else begin
      unique case (state_q)
        ST_HALTED:  if (req_run_set) nxt = ST_RUNNING;
        ST_RUNNING: if (mem_fail || req_run_clr) nxt = ST_HALTING;
        ST_HALTING: begin
          if (req_run_set)                  nxt = ST_RUNNING;
          else if (!txn_active || txn_done) nxt = ST_HALTED;
        end
        default: nxt = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HALTED;
    else        state_q <= nxt;
  end

  assign state        = state_q;
  assign rst_active   = (state_q == ST_RESET);
  assign sched_en     = (state_q == ST_RUNNING);
  assign reset_strobe = rst_active && rst_first;

  AST_HALT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALTING && txn_active && !txn_done && !req_reset && !req_run_set)
      |=> (state_q == ST_HALTING)) else $error("halt did not wait"); // R4
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_strobe |=> !reset_strobe) else $error("strobe too long"); // R8
endmodule

// File: rtl/hc_run_ctrl.sv
module hc_run_ctrl
  import hcrc_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  input  logic            txn_active,
  input  logic            txn_done,
  input  logic            mem_rd_valid,
  input  logic            mem_rd_ok,
  output logic            run_bit,
  output logic            halted,
  output logic            reset_bit,
  output logic            sched_en,
  output logic            txn_abort,
  output logic            op_rst,
  output logic            own_revert
);
  logic req_reset, req_run_set, req_run_clr;
  logic rst_start, rst_active, rst_first, rst_done, strobe;
  hc_state_e state, nxt;
  logic run_q, halted_q, reset_q;

  hcrc_wr_dec u_dec (
    .wr_en(wr_en), .wr_data(wr_data),
    .req_reset(req_reset), .req_run_set(req_run_set), .req_run_clr(req_run_clr)
  );

  hcrc_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .active(rst_active),
    .first(rst_first), .done(rst_done)
  );

  hcrc_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req_reset), .req_run_set(req_run_set), .req_run_clr(req_run_clr),
    .txn_active(txn_active), .txn_done(txn_done),
    .mem_fail(mem_rd_valid & ~mem_rd_ok),
    .rst_first(rst_first), .rst_done(rst_done),
    .state(state), .nxt(nxt), .rst_start(rst_start), .rst_active(rst_active),
    .sched_en(sched_en), .reset_strobe(strobe)
  );

  // Software-visible bits held in their own flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      halted_q <= 1'b1;
      reset_q  <= 1'b0;
    end else begin
      run_q    <= (nxt == ST_RUNNING);
      halted_q <= (nxt == ST_HALTED);
      reset_q  <= (nxt == ST_RESET);
    end
  end

  assign run_bit    = run_q;
  assign halted     = halted_q;
  assign reset_bit  = reset_q;
  assign txn_abort  = strobe;
  assign op_rst     = strobe;
  assign own_revert = strobe;

  AST_RUN_HALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && halted_q)) else $error("run and halted both set"); // R3
  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_q && !rst_done) |=> reset_q) else $error("reset cut short"); // R7
  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_q) |-> (halted_q && !run_q)) else $error("bad reset exit"); // R6
  AST_MEM_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mem_rd_valid && !mem_rd_ok) |=> !run_q) else $error("run kept"); // R5
  AST_SCHED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sched_en |-> run_q) else $error("sched without run"); // R9
endmodule

// File: tb/hc_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module hc_run_ctrl_tb_top;
  localparam int RSTC = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, txn_active = 0, txn_done = 0, mem_rd_valid = 0, mem_rd_ok = 0;
  logic [1:0] wr_data = 0;
  logic run_bit, halted, reset_bit, sched_en, txn_abort, op_rst, own_revert;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hc_run_ctrl #(.RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .txn_active(txn_active), .txn_done(txn_done),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ok(mem_rd_ok),
    .run_bit(run_bit), .halted(halted), .reset_bit(reset_bit),
    .sched_en(sched_en), .txn_abort(txn_abort), .op_rst(op_rst),
    .own_revert(own_revert)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // {run_bit, halted, reset_bit, sched_en}
  function automatic logic [3:0] st();
    return {run_bit, halted, reset_bit, sched_en};
  endfunction

  task automatic wr(logic [1:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(); rst_n = 1; tick();
  endtask

  task automatic t_defaults();
    do_reset();
    chk("R1", "defaults", st(), 4'b0100);
  endtask

  task automatic t_run_stop();
    wr(2'b01);
    chk("R2", "run set", st(), 4'b1001);
    chk("R3", "no run+halted", {3'b0, run_bit & halted}, 4'b0);
    txn_active = 1;
    wr(2'b00);
    chk("R4", "halting", st(), 4'b0000);
    tick(); tick(); tick();
    chk("R4", "still halting", st(), 4'b0000);
    txn_active = 0; tick();
    chk("R4", "halted after idle", st(), 4'b0100);
  endtask

  task automatic t_done_and_resume();
    wr(2'b01); txn_active = 1;
    wr(2'b00);
    wr(2'b01);
    chk("R10", "resume from halting", st(), 4'b1001);
    wr(2'b00);
    txn_done = 1; tick(); txn_done = 0; txn_active = 0;
    chk("R4", "halted after done", st(), 4'b0100);
  endtask

  task automatic t_mem_fail();
    wr(2'b01);
    mem_rd_valid = 1; mem_rd_ok = 1; tick();
    chk("R5", "good read keeps run", st(), 4'b1001);
    mem_rd_ok = 0; tick(); mem_rd_valid = 0;
    chk("R5", "bad read clears run", st(), 4'b0000);
    tick();
    chk("R5", "then halted", st(), 4'b0100);
  endtask

  task automatic t_reset();
    txn_active = 1;
    wr(2'b11);
    chk("R6", "reset bit set, run not", st(), 4'b0010);
    chk("R8", "strobes first cycle", {1'b0, txn_abort, op_rst, own_revert}, 4'b0111);
    tick();
    chk("R8", "strobes one cycle", {1'b0, txn_abort, op_rst, own_revert}, 4'b0000);
    txn_active = 0;
    wr(2'b00);
    chk("R7", "write 0 ignored", st(), 4'b0010);
    wr(2'b01);
    chk("R7", "run write ignored", st(), 4'b0010);
    for (int i = 0; i < RSTC - 4; i++) tick();
    chk("R6", "last reset cycle", st(), 4'b0010);
    tick();
    chk("R6", "reset done halted", st(), 4'b0100);
  endtask

  task automatic t_reset_from_run();
    wr(2'b01);
    wr(2'b10);
    chk("R6", "reset from running", st(), 4'b0010);
    chk("R9", "sched off in reset", {3'b0, sched_en}, 4'b0);
    for (int i = 0; i < RSTC; i++) tick();
    chk("R6", "halted after reset", st(), 4'b0100);
  endtask

  task automatic t_chip_reset_mid_run();
    wr(2'b01);
    do_reset();
    chk("R1", "chip reset while running", st(), 4'b0100);
  endtask

  initial begin
    t_defaults();
    t_run_stop();
    t_done_and_resume();
    t_mem_fail();
    t_reset();
    t_reset_from_run();
    t_chip_reset_mid_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule